// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Counter

This block keeps the tap position of a resistor string with 2^POS_W taps (128 by default). An external count clock, an active-low chip select and a direction level come in asynchronously. The block resynchronizes all three into the fast system clock domain. Each falling edge of the count clock that arrives while the chip is selected moves the position one tap up or down. The position stops at either end instead of wrapping around. Reset loads a preset value, which is midscale by default.

The block drives the binary position and a one-hot tap-select vector for the switch array. It also gives a one-cycle pulse for every step it accepts. Debouncing of the count clock is the job of logic in front of this block.

Top module: `wiper_updown_pot`

## Requirements
- R1: While reset is applied and in the first cycle after it, the code is 0x40 (PRESET), only tap-select bit 64 is set, and step_done is low.
- R2: A count-clock falling edge with chip select low and the direction input at 1 raises the code by exactly one.
- R3: A count-clock falling edge with chip select low and the direction input at 0 lowers the code by exactly one.
- R4: A count-clock falling edge with chip select high leaves the code unchanged and gives no step_done pulse, for either direction value.
- R5: An up edge at code 0x7F and a down edge at code 0x00 are ignored. The code stays at that end and no step_done pulse is given.
- R6: The tap-select output has exactly one bit set. That bit sits at the index equal to the current code and changes in the same cycle as the code.
- R7: Each accepted step gives step_done high for exactly one system cycle, in the same cycle the new code appears. Code changes only by one, and only together with step_done.
- R8: Only falling edges count. A rising edge of the count clock, holding it low, or changing the direction input after the edge has been taken does not cause any further step.
- R9: The new code and the step_done pulse appear on the third rising system-clock edge after the count clock falls (SYNC_STAGES + 1 registers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clk_i | input | 1 | Asynchronous count clock; acts on its falling edge |
| cs_n_i | input | 1 | Asynchronous active-low chip select |
| dir_up_i | input | 1 | Direction: 1 counts up (toward the top code), 0 counts down |
| code_o | output | POS_W | Current tap position |
| tap_sel_o | output | 2^POS_W | One-hot tap select, bit index equals code_o |
| step_done_o | output | 1 | One-cycle pulse per accepted step |

## Verification
The bench runs the code to both ends and then applies further edges in the same direction. A counter that wraps would show 0x00 after 0x7F, or 0x7F after 0x00, and would also give a stray done pulse. Edges with chip select high are applied in both directions; a design that ignored the select would drift. Each count-clock pulse is held low for several system cycles, and the direction is flipped while the clock is still low. A level-triggered or badly edge-detected design would then step several times or reverse. The bench also checks the exact latency of the done pulse and compares the one-hot vector with the expected code after every edge, so a tap decode that is off by one or a shifted pipeline is caught.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

   // Command produced by the edge qualifier for one system cycle
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_cmd_e;

   // Midpoint code for a given position width
   function automatic int unsigned midscale(input int unsigned w);
      return (w == 0) ? 0 : (1 << (w - 1));
   endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
   parameter int unsigned            WIDTH   = 1,
   parameter int unsigned            STAGES  = 2,
   parameter logic [WIDTH-1:0]       RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= RST_VAL;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/wiper_edge_qual.sv
module wiper_edge_qual
   import wiper_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cnt_clk_s,
   input  logic      cs_n_s,
   input  logic      dir_up_s,
   output step_cmd_e cmd_o
);

   // Previous count-clock sample. It resets low, so reset release
   // can never look like a falling edge.
   logic prev_q;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cnt_clk_s;
   end

   assign fall = prev_q & ~cnt_clk_s;

   // Chip select and direction are taken in the cycle of the fall only
   always_comb begin
      cmd_o = STEP_HOLD;
      if (fall && !cs_n_s) cmd_o = dir_up_s ? STEP_UP : STEP_DOWN;
   end

endmodule

// File: rtl/wiper_sat_counter.sv
module wiper_sat_counter
   import wiper_pkg::*;
#(
   parameter int unsigned POS_W  = 7,
   parameter int unsigned PRESET = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_cmd_e        cmd_i,
   output logic [POS_W-1:0] code_o,
   output logic             step_done_o
);

   localparam logic [POS_W-1:0] TOP_CODE = '1;
   localparam logic [POS_W-1:0] BOT_CODE = '0;
   localparam logic [POS_W-1:0] RST_CODE = POS_W'(PRESET);

   logic [POS_W-1:0] code_q, code_d;
   logic             done_q, done_d;

   always_comb begin
      code_d = code_q;
      done_d = 1'b0;
      unique case (cmd_i)
         STEP_UP: if (code_q != TOP_CODE) begin
            code_d = code_q + 1'b1;
            done_d = 1'b1;
         end
         STEP_DOWN: if (code_q != BOT_CODE) begin
            code_d = code_q - 1'b1;
            done_d = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= RST_CODE;
         done_q <= 1'b0;
      end else begin
         code_q <= code_d;
         done_q <= done_d;
      end
   end

   assign code_o      = code_q;
   assign step_done_o = done_q;

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
   parameter int unsigned POS_W = 7,
   localparam int unsigned TAPS = 1 << POS_W
) (
   input  logic [POS_W-1:0] code_i,
   output logic [TAPS-1:0]  tap_sel_o
);

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign tap_sel_o[t] = (code_i == POS_W'(t));
   end

endmodule

// File: rtl/wiper_updown_pot.sv
module wiper_updown_pot
   import wiper_pkg::*;
#(
   parameter int unsigned POS_W       = 7,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PRESET      = midscale(POS_W),
   localparam int unsigned TAPS       = 1 << POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_clk_i,
   input  logic             cs_n_i,
   input  logic             dir_up_i,
   output logic [POS_W-1:0] code_o,
   output logic [TAPS-1:0]  tap_sel_o,
   output logic             step_done_o
);

   // Elaboration-time parameter checks
   if (POS_W < 1 || POS_W > 10) begin : g_bad_pos_w
      $error("wiper_updown_pot: POS_W must be 1..10");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wiper_updown_pot: SYNC_STAGES must be at least 2");
   end
   if (PRESET >= TAPS) begin : g_bad_preset
      $error("wiper_updown_pot: PRESET must be below 2**POS_W");
   end

   // Synchronized vector: {count clock, chip select, direction}
   // Reset values: clock low, deselected, down.
   logic [2:0] raw_in, sync_out;
   step_cmd_e  step_cmd;

   assign raw_in = {cnt_clk_i, cs_n_i, dir_up_i};

   wiper_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b010)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_out)
   );

   wiper_edge_qual u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_clk_s (sync_out[2]),
      .cs_n_s    (sync_out[1]),
      .dir_up_s  (sync_out[0]),
      .cmd_o     (step_cmd)
   );

   wiper_sat_counter #(
      .POS_W  (POS_W),
      .PRESET (PRESET)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_i       (step_cmd),
      .code_o      (code_o),
      .step_done_o (step_done_o)
   );

   wiper_tap_decode #(
      .POS_W (POS_W)
   ) u_dec (
      .code_i    (code_o),
      .tap_sel_o (tap_sel_o)
   );

endmodule

// File: rtl/wiper_updown_pot_chk.sv
module wiper_updown_pot_chk
   import wiper_pkg::*;
#(
   parameter int unsigned POS_W = 7,
   localparam int unsigned TAPS = 1 << POS_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [POS_W-1:0] code_o,
   input logic [TAPS-1:0]  tap_sel_o,
   input logic             step_done_o,
   input step_cmd_e        step_cmd
);

   localparam logic [POS_W-1:0] TOP_CODE = '1;
   localparam logic [POS_W-1:0] BOT_CODE = '0;

   // R6: exactly one tap selected, at the code index
   a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel_o) == 1);
   a_r6_tap_at_code: assert property (@(posedge clk) disable iff (!rst_n)
      tap_sel_o[code_o] == 1'b1);

   // R7: code moves by one tap, and only together with step_done
   a_r7_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o != $past(code_o)) |->
         (code_o == $past(code_o) + 1'b1 || code_o == $past(code_o) - 1'b1));
   a_r7_change_has_done: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o != $past(code_o)) |-> step_done_o);
   a_r7_done_has_change: assert property (@(posedge clk) disable iff (!rst_n)
      step_done_o |-> (code_o != $past(code_o)));

   // R4/R8: no qualified command, no movement
   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd == STEP_HOLD) |=> $stable(code_o));

   // R5: saturation at both ends
   a_r5_top_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o == TOP_CODE && step_cmd == STEP_UP) |=> (code_o == TOP_CODE && !step_done_o));
   a_r5_bottom_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o == BOT_CODE && step_cmd == STEP_DOWN) |=> (code_o == BOT_CODE && !step_done_o));

   // R2/R3: accepted commands move in their own direction
   a_r2_up_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd == STEP_UP && code_o != TOP_CODE) |=> (code_o == $past(code_o) + 1'b1));
   a_r3_down_moves_down: assert property (@(posedge clk) disable iff (!rst_n)
      (step_cmd == STEP_DOWN && code_o != BOT_CODE) |=> (code_o == $past(code_o) - 1'b1));

endmodule

bind wiper_updown_pot wiper_updown_pot_chk #(
   .POS_W (POS_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .code_o      (code_o),
   .tap_sel_o   (tap_sel_o),
   .step_done_o (step_done_o),
   .step_cmd    (step_cmd)
);

// File: tb/tb_wiper_updown_pot.sv
module tb_wiper_updown_pot;

   localparam int POS_W = 7;
   localparam int TAPS  = 1 << POS_W;
   localparam int TOPV  = TAPS - 1;
   localparam int MID   = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cnt_clk_i = 1'b1;
   logic             cs_n_i = 1'b1;
   logic             dir_up_i = 1'b0;
   logic [POS_W-1:0] code_o;
   logic [TAPS-1:0]  tap_sel_o;
   logic             step_done_o;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_code = MID;

   always #2.5 clk = ~clk;

   wiper_updown_pot dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cnt_clk_i   (cnt_clk_i),
      .cs_n_i      (cs_n_i),
      .dir_up_i    (dir_up_i),
      .code_o      (code_o),
      .tap_sel_o   (tap_sel_o),
      .step_done_o (step_done_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      logic [TAPS-1:0] exp_tap;
      exp_tap = '0;
      exp_tap[exp_code] = 1'b1;
      check(code_o == POS_W'(exp_code), req, int'(code_o), exp_code);
      check(tap_sel_o == exp_tap, {req, "/R6 tap"}, $countones(tap_sel_o), 1);
   endtask

   // One count-clock pulse; bench model decides whether it is accepted
   task automatic count_edge(input logic cs_n, input logic up, input bit flip_dir, input string req);
      int pulses   = 0;
      int first_at = -1;
      bit accept;
      accept = !cs_n && !(up && exp_code == TOPV) && !(!up && exp_code == 0);
      @(negedge clk);
      cs_n_i   = cs_n;
      dir_up_i = up;
      @(negedge clk);
      @(negedge clk);
      cnt_clk_i = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         if (k == 4 && flip_dir) dir_up_i = ~up;
         if (step_done_o) begin
            pulses++;
            if (first_at < 0) first_at = k;
         end
      end
      cnt_clk_i = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (step_done_o) pulses++;
      end
      if (accept) exp_code = up ? exp_code + 1 : exp_code - 1;
      check(pulses == int'(accept), {req, " done pulses (R7)"}, pulses, int'(accept));
      if (accept) check(first_at == 3, "R9 latency", first_at, 3);
      check_outputs(req);
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cnt_clk_i = 1'b1;
      cs_n_i = 1'b1;
      repeat (3) @(negedge clk);
      check(code_o == POS_W'(MID), "R1 in reset", int'(code_o), MID);
      rst_n = 1'b1;
      exp_code = MID;
      @(negedge clk);
      check_outputs("R1 after reset");
      check(step_done_o == 1'b0, "R1 done low", int'(step_done_o), 0);
   endtask

   task automatic t_reset();
      apply_reset();
   endtask

   task automatic t_count_up();
      for (int i = 0; i < 5; i++) count_edge(1'b0, 1'b1, 1'b0, "R2 up");
   endtask

   task automatic t_count_down();
      for (int i = 0; i < 3; i++) count_edge(1'b0, 1'b0, 1'b0, "R3 down");
   endtask

   task automatic t_cs_blocked();
      count_edge(1'b1, 1'b1, 1'b0, "R4 cs high up");
      count_edge(1'b1, 1'b0, 1'b0, "R4 cs high down");
   endtask

   task automatic t_dir_flip_low();
      count_edge(1'b0, 1'b1, 1'b1, "R8 flip after up edge");
      count_edge(1'b0, 1'b0, 1'b1, "R8 flip after down edge");
   endtask

   task automatic t_top_sat();
      while (exp_code < TOPV) count_edge(1'b0, 1'b1, 1'b0, "R2 climb");
      for (int i = 0; i < 3; i++) count_edge(1'b0, 1'b1, 1'b0, "R5 top sticks");
      check(code_o == POS_W'(TOPV), "R5 top", int'(code_o), TOPV);
   endtask

   task automatic t_bottom_sat();
      while (exp_code > 0) count_edge(1'b0, 1'b0, 1'b0, "R3 descend");
      for (int i = 0; i < 3; i++) count_edge(1'b0, 1'b0, 1'b0, "R5 bottom sticks");
      check(code_o == '0, "R5 bottom", int'(code_o), 0);
      count_edge(1'b0, 1'b1, 1'b0, "R2 leave bottom");
   endtask

   task automatic t_reset_mid();
      count_edge(1'b0, 1'b1, 1'b0, "R2 before reset");
      apply_reset();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_count_up();
      t_count_down();
      t_cs_blocked();
      t_dir_flip_low();
      t_top_sat();
      t_bottom_sat();
      t_reset_mid();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule